// File: doc/BRIEF.md
# SATA PHY Bring-Up Sequencer

This block runs the start-up steps that take a SATA PHY out of reset and hold the host controller back until the PHY's receive PLL reports lock. It talks to the PHY's internal register space through a simple request/response port: it presents one request for a single cycle and, for reads, waits for a completion or an error pulse before it moves on. A pulse on `start` launches the sequence. The sequencer first writes a reset value into the PHY clock/reset register. That write is never acknowledged, so the sequencer does not wait for a response to it.

It then polls the lane-0 output status register with a fixed pause before every read. It stops when the PLL-state bit comes back set, when the interface returns an error, or when the retry budget is used up. On success it raises `ready`, the staggered spin-up and port-0-implemented flags toward the host, and a one-millisecond tick reload. The reload value is the bus clock frequency divided by 1000 and is computed when the design is elaborated. On failure it raises `error`. Both outcomes hold until the next `start`.

Top module: `sata_phy_boot`

## Requirements
- R1: After reset, `ready`, `error`, `busy`, `req_valid`, `cap_staggered` and `port0_impl` are all 0, and `tick_reload` is 0.
- R2: The first request after an accepted `start` is a single-cycle write (`req_write`=1) of data 0x0001 to address 0x7F3F. The sequencer does not wait for a response to this write.
- R3: Every read request (`req_write`=0) targets address 0x2003. Each read is issued exactly DLY_CYC+1 cycles after the cycle of the preceding reset write or of the preceding non-locking `resp_done`, where DLY_CYC = BUS_HZ/1_000_000 × DELAY_US.
- R4: While a read is outstanding, no new request is issued. A read is outstanding from its request cycle until `resp_done` or `resp_err`.
- R5: A `resp_done` whose `resp_rdata` has bit 1 set ends polling with `ready`=1. No further request follows. The other data bits do not affect the lock decision.
- R6: At most MAX_TRIES reads are issued per sequence. If the MAX_TRIES-th read completes without bit 1 set, `error` becomes 1 and polling stops.
- R7: A `resp_err` during a read ends the sequence at once with `error`=1. It takes priority over `resp_done` in the same cycle.
- R8: `ready` and `error` are never 1 together. Each stays set until a `start` is accepted, which clears both on the next cycle. `start` is ignored while `busy`=1.
- R9: While `ready`=1, `tick_reload` equals BUS_HZ/1000 and `cap_staggered` and `port0_impl` are 1. Otherwise all three are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches the sequence (ignored while busy) |
| req_valid | output | 1 | Single-cycle request strobe |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 16 | PHY register address |
| req_wdata | output | 16 | Write data |
| resp_done | input | 1 | Read completion pulse |
| resp_err | input | 1 | Read failure pulse |
| resp_rdata | input | 16 | Read data, valid with `resp_done` |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | PLL locked, host may start (sticky) |
| error | output | 1 | Bring-up failed (sticky) |
| tick_reload | output | 32 | One-millisecond timer reload, valid while ready |
| cap_staggered | output | 1 | Staggered spin-up capability toward the host |
| port0_impl | output | 1 | Port 0 implemented flag toward the host |

## Verification
The assertions assume that the register interface answers only reads and returns exactly one `resp_done` or `resp_err` per read. They also assume no response arrives while no read is pending. The bench's responder follows these rules: it ignores writes and replies to each read once, a fixed three cycles after the request. Scenarios change only which read returns lock or error. `start` is pulsed only after reset has been released, and once while the block is busy to test that it is ignored.

// File: rtl/phy_boot_pkg.sv
package phy_boot_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] CLK_RST_ADDR   = 16'h7F3F;
    localparam logic [DATA_W-1:0] CLK_RST_VALUE  = 16'h0001;
    localparam logic [ADDR_W-1:0] LANE_STAT_ADDR = 16'h2003;
    localparam logic [DATA_W-1:0] PLL_LOCK_MASK  = 16'h0002;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_WR,
        ST_PAUSE,
        ST_READ,
        ST_WAIT,
        ST_DONE,
        ST_FAIL
    } boot_state_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } phy_req_t;

    function automatic int reload_of(input int hz);
        return hz / 1000;
    endfunction

    function automatic int pause_cycles(input int hz, input int us);
        return (hz / 1_000_000) * us;
    endfunction

endpackage

// File: rtl/phy_boot_pause.sv
module phy_boot_pause #(
    parameter int DLY_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(DLY_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == CW'(DLY_CYC - 1));
endmodule

// File: rtl/phy_boot_tries.sv
module phy_boot_tries #(
    parameter int MAX_TRIES = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int TW = $clog2(MAX_TRIES + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == TW'(MAX_TRIES));
endmodule

// File: rtl/phy_boot_fsm.sv
module phy_boot_fsm
    import phy_boot_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        pause_over,
    input  logic        tries_last,
    input  logic        resp_done,
    input  logic        resp_err,
    input  logic        lock_seen,
    output boot_state_e state,
    output logic        tries_clr,
    output logic        tries_inc
);
    boot_state_e nxt;
    logic        can_start;

    assign can_start = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_FAIL);
    assign tries_clr = can_start && start;
    assign tries_inc = (state == ST_READ);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE, ST_DONE, ST_FAIL: if (start) nxt = ST_RST_WR;
            ST_RST_WR:                 nxt = ST_PAUSE;
            ST_PAUSE:                  if (pause_over) nxt = ST_READ;
            ST_READ:                   nxt = ST_WAIT;
            ST_WAIT: begin
                if (resp_err) begin
                    nxt = ST_FAIL;
                end else if (resp_done) begin
                    if (lock_seen)       nxt = ST_DONE;
                    else if (tries_last) nxt = ST_FAIL;
                    else                 nxt = ST_PAUSE;
                end
            end
            default:                   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/sata_phy_boot.sv
module sata_phy_boot
    import phy_boot_pkg::*;
#(
    parameter int BUS_HZ    = 132_000_000,
    parameter int DELAY_US  = 100,
    parameter int MAX_TRIES = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    output logic        req_valid,
    output logic        req_write,
    output logic [15:0] req_addr,
    output logic [15:0] req_wdata,
    input  logic        resp_done,
    input  logic        resp_err,
    input  logic [15:0] resp_rdata,
    output logic        busy,
    output logic        ready,
    output logic        error,
    output logic [31:0] tick_reload,
    output logic        cap_staggered,
    output logic        port0_impl
);
    localparam int          DLY_CYC    = pause_cycles(BUS_HZ, DELAY_US);
    localparam logic [31:0] RELOAD_VAL = 32'(reload_of(BUS_HZ));

    boot_state_e state;
    logic        pause_over, tries_last, tries_clr, tries_inc, lock_seen;
    phy_req_t    req;

    // Lock decision masks the whole word so only the PLL-state bit matters.
    assign lock_seen = (resp_rdata & PLL_LOCK_MASK) == PLL_LOCK_MASK;

    phy_boot_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .pause_over (pause_over),
        .tries_last (tries_last),
        .resp_done  (resp_done),
        .resp_err   (resp_err),
        .lock_seen  (lock_seen),
        .state      (state),
        .tries_clr  (tries_clr),
        .tries_inc  (tries_inc)
    );

    phy_boot_pause #(.DLY_CYC(DLY_CYC)) u_pause (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_PAUSE),
        .expired (pause_over)
    );

    phy_boot_tries #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk  (clk),
        .rst  (rst),
        .clr  (tries_clr),
        .inc  (tries_inc),
        .last (tries_last)
    );

    always_comb begin
        req = '0;
        if (state == ST_RST_WR) begin
            req.valid = 1'b1;
            req.write = 1'b1;
            req.addr  = CLK_RST_ADDR;
            req.wdata = CLK_RST_VALUE;
        end else if (state == ST_READ) begin
            req.valid = 1'b1;
            req.addr  = LANE_STAT_ADDR;
        end
    end

    assign req_valid     = req.valid;
    assign req_write     = req.write;
    assign req_addr      = req.addr;
    assign req_wdata     = req.wdata;

    assign ready         = (state == ST_DONE);
    assign error         = (state == ST_FAIL);
    assign busy          = !(state == ST_IDLE || ready || error);
    assign tick_reload   = ready ? RELOAD_VAL : 32'd0;
    assign cap_staggered = ready;
    assign port0_impl    = ready;
endmodule

// File: rtl/sata_phy_boot_chk.sv
module sata_phy_boot_chk
    import phy_boot_pkg::*;
#(
    parameter int BUS_HZ    = 132_000_000,
    parameter int MAX_TRIES = 50
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        req_valid,
    input logic        req_write,
    input logic [15:0] req_addr,
    input logic [15:0] req_wdata,
    input logic        resp_done,
    input logic        resp_err,
    input logic        ready,
    input logic        error,
    input logic [31:0] tick_reload,
    input logic        cap_staggered,
    input logic        port0_impl
);
    localparam int TW = $clog2(MAX_TRIES + 2);

    logic          pending;
    logic [TW-1:0] reads;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            reads   <= '0;
        end else begin
            if (req_valid && !req_write) pending <= 1'b1;
            else if (resp_done || resp_err) pending <= 1'b0;
            if (req_valid && req_write) reads <= '0;
            else if (req_valid) reads <= reads + 1'b1;
        end
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ready && !error && !req_valid && tick_reload == 32'd0));

    assert_reset_write_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |-> (req_addr == CLK_RST_ADDR && req_wdata == CLK_RST_VALUE));

    assert_read_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |-> (req_addr == LANE_STAT_ADDR));

    assert_single_outstanding_R4: assert property (@(posedge clk) disable iff (rst)
        pending |-> !req_valid);

    assert_read_budget_R6: assert property (@(posedge clk) disable iff (rst)
        reads <= TW'(MAX_TRIES));

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(ready && error));

    assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> ready);

    assert_error_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (error && !start) |=> error);

    assert_host_flags_R9: assert property (@(posedge clk) disable iff (rst)
        ready |-> (tick_reload == 32'(reload_of(BUS_HZ)) && cap_staggered && port0_impl));

    assert_flags_low_R9: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (tick_reload == 32'd0 && !cap_staggered && !port0_impl));
endmodule

bind sata_phy_boot sata_phy_boot_chk #(
    .BUS_HZ    (BUS_HZ),
    .MAX_TRIES (MAX_TRIES)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .resp_done     (resp_done),
    .resp_err      (resp_err),
    .ready         (ready),
    .error         (error),
    .tick_reload   (tick_reload),
    .cap_staggered (cap_staggered),
    .port0_impl    (port0_impl)
);

// File: tb/sata_phy_boot_test.sv
module sata_phy_boot_test;
    localparam int CLK_PERIOD = 10;
    localparam int BUS_HZ     = 1_000_000;
    localparam int DELAY_US   = 100;
    localparam int MAX_TRIES  = 50;
    localparam int DLY        = (BUS_HZ / 1_000_000) * DELAY_US;
    localparam int EXP_RELOAD = BUS_HZ / 1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        req_valid, req_write, busy, ready, error, cap_staggered, port0_impl;
    logic [15:0] req_addr, req_wdata;
    logic        resp_done = 1'b0;
    logic        resp_err = 1'b0;
    logic [15:0] resp_rdata = 16'h0000;
    logic [31:0] tick_reload;

    int checks = 0;
    int fails = 0;

    // responder state and scenario knobs
    int cyc = 0;
    int lock_at = 0;
    int err_at = 0;
    int rd_cnt = 0;
    int wr_total = 0;
    int cd = 0;
    int last_evt = 0;
    bit gap_bad = 0;
    bit addr_bad = 0;
    bit wr_bad = 0;

    sata_phy_boot #(.BUS_HZ(BUS_HZ), .DELAY_US(DELAY_US), .MAX_TRIES(MAX_TRIES)) uut (
        .clk(clk), .rst(rst), .start(start),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_done(resp_done), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .busy(busy), .ready(ready), .error(error), .tick_reload(tick_reload),
        .cap_staggered(cap_staggered), .port0_impl(port0_impl)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Register-interface model: ignores writes, answers each read after 3 cycles.
    always @(negedge clk) begin
        resp_done <= 1'b0;
        resp_err  <= 1'b0;
        if (req_valid && req_write) begin
            wr_total <= wr_total + 1;
            rd_cnt   <= 0;
            last_evt <= cyc;
            gap_bad  <= 1'b0;
            addr_bad <= 1'b0;
            if (req_addr != 16'h7F3F || req_wdata != 16'h0001) wr_bad <= 1'b1;
        end else if (req_valid) begin
            rd_cnt <= rd_cnt + 1;
            cd     <= 3;
            if (cyc - last_evt != DLY + 1) gap_bad <= 1'b1;
            if (req_addr != 16'h2003) addr_bad <= 1'b1;
        end else if (cd > 0) begin
            cd <= cd - 1;
            if (cd == 1) begin
                if (err_at != 0 && rd_cnt == err_at) begin
                    resp_err <= 1'b1;
                end else begin
                    resp_done <= 1'b1;
                    last_evt  <= cyc;
                    resp_rdata <= (lock_at != 0 && rd_cnt >= lock_at) ? 16'h5A57 : 16'hFFFD;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (ready || error) break;
        end
    endtask

    task automatic idle_for(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!ready && !error && !busy, "R1 status", {ready, error, busy}, 0);
        check(!req_valid, "R1 no request", req_valid, 0);
        check(tick_reload == 0 && !cap_staggered && !port0_impl, "R1 host flags",
              int'(tick_reload), 0);
    endtask

    task automatic t_lock_third();
        lock_at = 3; err_at = 0;
        pulse_start();
        check(req_valid && req_write && wr_total == 0, "R2 first request is write", req_write, 1);
        wait_end();
        check(!wr_bad, "R2 write addr/data", wr_bad, 0);
        check(!gap_bad, "R3 read spacing", gap_bad, 0);
        check(!addr_bad, "R3 read address", addr_bad, 0);
        check(ready && !error, "R5 ready on lock", ready, 1);
        check(rd_cnt == 3, "R5 reads until lock", rd_cnt, 3);
        check(tick_reload == EXP_RELOAD, "R9 reload", int'(tick_reload), EXP_RELOAD);
        check(cap_staggered && port0_impl, "R9 host flags", {cap_staggered, port0_impl}, 3);
        idle_for(300);
        check(rd_cnt == 3 && !req_valid, "R5 polling stopped", rd_cnt, 3);
        check(ready && !error, "R8 ready sticky", ready, 1);
    endtask

    task automatic t_never_lock();
        lock_at = 0; err_at = 0;
        pulse_start();
        check(!ready && !error, "R8 start clears ready", ready, 0);
        wait_end();
        check(error && !ready, "R6 error on exhaustion", error, 1);
        check(rd_cnt == MAX_TRIES, "R6 read budget", rd_cnt, MAX_TRIES);
        check(!gap_bad, "R3 spacing across retries", gap_bad, 0);
        check(tick_reload == 0 && !cap_staggered && !port0_impl, "R9 flags low on error",
              int'(tick_reload), 0);
        idle_for(300);
        check(rd_cnt == MAX_TRIES && error, "R6 no reads after error", rd_cnt, MAX_TRIES);
    endtask

    task automatic t_lock_last();
        lock_at = MAX_TRIES; err_at = 0;
        pulse_start();
        check(!ready && !error, "R8 start clears error", error, 0);
        wait_end();
        check(ready && !error, "R6 lock on final read", ready, 1);
        check(rd_cnt == MAX_TRIES, "R6 reads on final lock", rd_cnt, MAX_TRIES);
    endtask

    task automatic t_read_err();
        lock_at = 6; err_at = 4;
        pulse_start();
        wait_end();
        check(error && !ready, "R7 error on read failure", error, 1);
        check(rd_cnt == 4, "R7 reads before failure", rd_cnt, 4);
        idle_for(300);
        check(rd_cnt == 4, "R7 no reads after failure", rd_cnt, 4);
    endtask

    task automatic t_start_busy();
        int w0;
        lock_at = 2; err_at = 0;
        w0 = wr_total;
        pulse_start();
        idle_for(10);
        check(busy, "R8 busy during sequence", busy, 1);
        pulse_start();
        wait_end();
        check(wr_total - w0 == 1, "R8 start ignored while busy", wr_total - w0, 1);
        check(ready && rd_cnt == 2, "R8 sequence unaffected", rd_cnt, 2);
    endtask

    initial begin
        fork
            begin
                idle_for(3);
                @(negedge clk) rst = 1'b0;
                t_reset();
                t_lock_third();
                t_never_lock();
                t_lock_last();
                t_read_err();
                t_start_busy();
            end
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule